// File: doc/BRIEF.md
# Three-Operand Unsigned Multiplier

This block multiplies three unsigned operands of `W` bits each and returns their complete product of `3*W` bits. All three operands arrive in the same cycle. AND gates form the partial products of the first two operands. A chain of (3:2) counter rows folds them into a sum vector and a carry vector. That pair is never resolved into a single number. Each of its two vectors is ANDed with every bit of the third operand. A row of (4:2) compressors, each made from two chained full adders, then folds those rows into a second running pair. A single ripple-carry adder at the output resolves the final pair. It has a half adder at bit 0 and full adders above it.

A parameter adds one output register with a synchronous, active-high reset. With the register enabled, the `vld_o` flag marks which clock carries the result of the operands that `vld_i` marked. With the register disabled, the block is purely combinational, and `vld_o` is a copy of `vld_i`.

Top module: `tri_mult`

## Requirements
- R1: For every combination of unsigned operands `x`, `y` and `z`, the output `prod` equals `x*y*z` exactly, over the full `3*W` bits.
- R2: When any one operand is zero, `prod` is zero.
- R3: The first two operands are held inside the block as a sum/carry pair whose total, modulo 2^(3W), equals `x*y`. With `z` = 1, `prod` therefore equals `x*y`.
- R4: With all three operands at 2^W-1, `prod` equals (2^W-1)^3 and loses no upper bit. For W = 4 this value is 3375, hex D2F.
- R5: With `OUT_REG` = 1, `prod` and `vld_o` change exactly one rising clock edge after the inputs they belong to, and `vld_o` repeats `vld_i` from that edge.
- R6: With `OUT_REG` = 1, a high `rst` at a rising edge sets `prod` and `vld_o` to zero after that edge, whatever the other inputs are.
- R7: With `OUT_REG` = 0, `prod` follows the operands with no clock edge in between.
- R8: The same structure is exact for W = 8, with a 24-bit product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| vld_i | input | 1 | Marks the operands presented this cycle |
| x | input | W | First operand, unsigned |
| y | input | W | Second operand, unsigned |
| z | input | W | Third operand, unsigned |
| vld_o | output | 1 | Marks the cycle in which `prod` holds a marked result |
| prod | output | 3W | Product x*y*z |

## Verification
For W = 4, every one of the 4096 operand triples is applied, both to a registered instance and to a combinational one. Within that sweep, the triples with a zero operand separate a correct zero result from a stray carry left in the redundant pair. The triples with `z` = 1 expose the resolved first-stage product directly. The all-ones triple fills every column and shows whether the top carries survive.

The registered output is sampled both before and after the edge, which separates a latency of one clock from a latency of zero or two. A reset pulse applied while the operands are nonzero shows that the clear takes precedence. A W = 8 instance is driven with corner triples and a stepped sweep, which tests whether the compressor and ripple chains scale.

// File: rtl/tri_mult.sv
`timescale 1ns/1ps
module tri_mult #(
  parameter int W       = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           vld_i,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  input  logic [W-1:0]   z,
  output logic           vld_o,
  output logic [3*W-1:0] prod
);
  localparam int N = 3 * W;
  localparam int Z = N - W;

  logic [N-1:0] xe, ye, ze;
  assign xe = {{Z{1'b0}}, x};
  assign ye = {{Z{1'b0}}, y};
  assign ze = {{Z{1'b0}}, z};

  // first pair: x*y accumulated through (3:2) counter rows
  logic [W:0][N-1:0] s1, c1;
  assign s1[0] = '0;
  assign c1[0] = '0;

  for (genvar j = 0; j < W; j++) begin : g_row1
    logic [N-1:0] pp;
    assign pp        = (xe & {N{y[j]}}) << j;
    assign s1[j+1]   = s1[j] ^ c1[j] ^ pp;
    assign c1[j+1]   = {(s1[j][N-2:0] & c1[j][N-2:0]) |
                        (s1[j][N-2:0] & pp[N-2:0]) |
                        (c1[j][N-2:0] & pp[N-2:0]), 1'b0};
  end

  // second pair: (s1+c1)*z through (4:2) compressor rows, two full adders each
  logic [W:0][N-1:0] s2, c2;
  assign s2[0] = '0;
  assign c2[0] = '0;

  for (genvar j = 0; j < W; j++) begin : g_row2
    logic [N-1:0] q0, q1, q2, q3, t, ci, sm;
    logic [N-2:0] co, cy;
    assign q0 = s2[j];
    assign q1 = c2[j];
    assign q2 = (s1[W] & {N{z[j]}}) << j;
    assign q3 = (c1[W] & {N{z[j]}}) << j;
    assign t  = q0 ^ q1 ^ q2;
    assign co = (q0[N-2:0] & q1[N-2:0]) | (q0[N-2:0] & q2[N-2:0]) |
                (q1[N-2:0] & q2[N-2:0]);
    assign ci = {co, 1'b0};
    assign sm = t ^ q3 ^ ci;
    assign cy = (t[N-2:0] & q3[N-2:0]) | (t[N-2:0] & ci[N-2:0]) |
                (q3[N-2:0] & ci[N-2:0]);
    assign s2[j+1] = sm;
    assign c2[j+1] = {cy, 1'b0};
  end

  // single carry-propagate step: half adder at bit 0, ripple above
  logic [N-1:0] sum;
  logic [N-1:1] rc;
  assign sum[0] = s2[W][0] ^ c2[W][0];
  assign rc[1]  = s2[W][0] & c2[W][0];
  for (genvar i = 1; i < N; i++) begin : g_cpa
    assign sum[i] = s2[W][i] ^ c2[W][i] ^ rc[i];
    if (i < N - 1) begin : g_cy
      assign rc[i+1] = (s2[W][i] & c2[W][i]) | (s2[W][i] & rc[i]) |
                       (c2[W][i] & rc[i]);
    end
  end

  a_r3_pair_sum: assert property (@(posedge clk) disable iff (rst)
    N'(s1[W] + c1[W]) == N'(xe * ye));

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        prod  <= '0;
        vld_o <= 1'b0;
      end else begin
        prod  <= sum;
        vld_o <= vld_i;
      end
    end

    a_r1_registered_product: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> prod == $past(N'(xe * ye * ze)));
    a_r5_valid_latency: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> vld_o == $past(vld_i));
    a_r6_reset_clear: assert property (@(posedge clk)
      rst |=> (prod == '0) && !vld_o);
  end else begin : g_comb
    assign prod  = sum;
    assign vld_o = vld_i;
  end
endmodule

// File: tb/sim_tri_mult.sv
`timescale 1ns/1ps
module sim_tri_mult;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vi = 1'b0;
  logic [3:0] a = '0, b = '0, c = '0;
  logic [7:0] a8 = '0, b8 = '0, c8 = '0;
  logic v0, v1, v2;
  logic [11:0] p0, p1;
  logic [23:0] p2;
  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tri_mult #(.W(4), .OUT_REG(1'b1)) u0 (.clk(clk), .rst(rst), .vld_i(vi),
    .x(a), .y(b), .z(c), .vld_o(v0), .prod(p0));
  tri_mult #(.W(4), .OUT_REG(1'b0)) u1 (.clk(clk), .rst(rst), .vld_i(vi),
    .x(a), .y(b), .z(c), .vld_o(v1), .prod(p1));
  tri_mult #(.W(8), .OUT_REG(1'b0)) u2 (.clk(clk), .rst(rst), .vld_i(vi),
    .x(a8), .y(b8), .z(c8), .vld_o(v2), .prod(p2));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tag4(input int x, input int y, input int z);
    if (x == 0 || y == 0 || z == 0) return "R2 zero operand";
    if (x == 15 && y == 15 && z == 15) return "R4 all ones";
    if (z == 1) return "R3 z=1 gives x*y";
    return "R1 product";
  endfunction

  initial begin
    #(4 * 200000);
    nbad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    longint prev_e;
    bit prev_v;
    repeat (3) @(negedge clk);
    chk(p0 == 12'd0, "R6 reset prod", p0, 0);
    chk(v0 == 1'b0, "R6 reset vld_o", v0, 0);
    rst = 1'b0;
    prev_e = 0;
    prev_v = 1'b0;
    for (int k = 0; k < 4096; k++) begin
      longint e;
      @(negedge clk);
      a = k[3:0]; b = k[7:4]; c = k[11:8];
      vi = k[0] ^ k[5];
      e = longint'(a) * longint'(b) * longint'(c);
      #1;
      chk(p1 == 12'(e), {tag4(a, b, c), " / R7 comb"}, p1, e);
      chk(p0 == 12'(prev_e), "R5 no early output", p0, prev_e);
      @(negedge clk);
      chk(p0 == 12'(e), {tag4(a, b, c), " / R5 registered"}, p0, e);
      chk(v0 == vi, "R5 vld_o follows vld_i", v0, vi);
      prev_e = e;
      prev_v = vi;
    end
    @(negedge clk);
    a = 4'd15; b = 4'd15; c = 4'd15; vi = 1'b1; rst = 1'b1;
    @(negedge clk);
    chk(p0 == 12'd0, "R6 sync clear prod", p0, 0);
    chk(v0 == 1'b0, "R6 sync clear vld_o", v0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(p0 == 12'd3375, "R4 after reset", p0, 3375);
    for (int k = 0; k < 3000; k++) begin
      longint e;
      @(negedge clk);
      if (k < 8) begin
        a8 = k[0] ? 8'd255 : 8'd1;
        b8 = k[1] ? 8'd255 : 8'd128;
        c8 = k[2] ? 8'd255 : 8'd0;
      end else begin
        a8 = 8'((k * 37 + 11) % 256);
        b8 = 8'((k * 101 + 3) % 256);
        c8 = 8'((k * 59 + 200) % 256);
      end
      e = longint'(a8) * longint'(b8) * longint'(c8);
      #1;
      chk(p2 == 24'(e), "R8 width 8 product", p2, e);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    done = 1'b1;
    $finish;
  end
endmodule